// File: doc/BRIEF.md
# DMA Channel Control Register File

This block holds the software-visible control and status state of a multi-channel descriptor DMA layer. A processor reaches it over a simple register bus: writes take effect on the clock edge where the write strobe is high, and reads return data one cycle after the read strobe. The block keeps a global configuration word, an error status word, an interrupt enable field, TX and RX channel-active set and reset words, and four per-direction interrupt status words. These are the end-of-buffer and descriptor-error words for TX and for RX. It also holds three banked windows of per-channel state: TX descriptor table pointers, RX descriptor table pointers and RX buffer sizes.

The numbers of TX and RX channels are parameters (`TX_CH`, `RX_CH`, each 1 to 32). The descriptor engine sits outside the block. It reports events through one-cycle pulse vectors that set status bits. Software clears those bits by writing ones. A write to the configuration word with its top bit set performs a soft reset of the control and status state. The per-channel windows survive both soft and hard reset.

The read path is a two-state machine. `BUS_IDLE` is entered from reset and from `BUS_RESP` when no read strobe is present. `BUS_RESP` is entered from either state whenever the read strobe is high, and while in it `rvalid` is asserted and `rdata` holds the captured word.

Top module: `dma_chan_regfile`

## Requirements
- R1: After hard reset the configuration word (offset 0x000) reads 0x0007C000. Interrupt enable (0x001), error status (0x002), TX set/reset (0x008/0x009), TX end-of-buffer/descriptor-error (0x00A/0x00B), RX set/reset (0x00C/0x00D) and RX end-of-buffer/descriptor-error (0x00E/0x00F) read zero.
- R2: A write to 0x000 stores the data ANDed with 0x00FFC087. When data bit 31 is set, the same write first clears every register named in R1 other than the configuration word, so bit 31 never reads back as one.
- R3: Error status and the four end-of-buffer and descriptor-error words are write-one-to-clear: each data bit that is one clears the matching stored bit, and bits written as zero keep their value.
- R4: Interrupt enable stores data bits 4:0 only; the other bits read zero.
- R5: TX set and TX reset store data bits 31:28 only. RX set and RX reset store data bits 31:30 only. All other bits read zero.
- R6: A one on bit c of an engine pulse vector sets bit c of the matching status word: `tx_eob_set` sets 0x00A, `tx_derr_set` sets 0x00B, `rx_eob_set` sets 0x00E, `rx_derr_set` sets 0x00F and `err_set` sets 0x002. Bits at or above the channel count read zero.
- R7: When a software clear and an engine set hit the same bit in the same cycle, the bit ends up set. When a soft reset and an engine set coincide, the soft reset wins and the bit ends up clear.
- R8: TX descriptor pointer c sits at 0x1A0+c and RX descriptor pointer c at 0x1C0+c, both 32 bits wide. RX buffer size c sits at 0x1E0+c and keeps only data bits 7:0.
- R9: An offset in a window at or past the channel count of that window reads zero and ignores writes. Unmapped offsets in 0x000-0x01F also read zero and ignore writes.
- R10: Neither soft reset nor hard reset changes the per-channel window contents.
- R11: `rvalid` is high exactly in the cycle after a cycle with `rd_en` high. `rdata` then holds the addressed word as it stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 9 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| err_set | input | 32 | Engine pulses setting error status bits |
| tx_eob_set | input | TX_CH | Engine pulses, TX end-of-buffer per channel |
| tx_derr_set | input | TX_CH | Engine pulses, TX descriptor error per channel |
| rx_eob_set | input | RX_CH | Engine pulses, RX end-of-buffer per channel |
| rx_derr_set | input | RX_CH | Engine pulses, RX descriptor error per channel |

## Verification
The assertions assume the inputs carry known values after reset and that an engine pulse vector is never wider in effect than its channel count. They also assume a read and a write are not issued to the same offset in the same cycle. If they were, the read returns the value from before the edge, which the read-path check tolerates but the status checks do not reason about. The stimulus changes inputs one nanosecond after each rising edge. It keeps reads and writes in separate cycles and holds every engine pulse for one cycle only. It deliberately lines up a clear with a set and a soft reset with a set to reach the precedence cases.

// File: rtl/chreg_pkg.sv
package chreg_pkg;

    localparam int ADDR_W  = 9;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 5;
    localparam int IEN_W   = 5;
    localparam int TXACT_W = 4;
    localparam int RXACT_W = 2;
    localparam int RXSZ_W  = 8;

    // scalar region: addr[8:4] == 0, low nibble selects the word
    localparam logic [3:0] REG_CFG    = 4'h0;
    localparam logic [3:0] REG_IEN    = 4'h1;
    localparam logic [3:0] REG_ERR    = 4'h2;
    localparam logic [3:0] REG_TXSET  = 4'h8;
    localparam logic [3:0] REG_TXRST  = 4'h9;
    localparam logic [3:0] REG_TXEOB  = 4'hA;
    localparam logic [3:0] REG_TXDERR = 4'hB;
    localparam logic [3:0] REG_RXSET  = 4'hC;
    localparam logic [3:0] REG_RXRST  = 4'hD;
    localparam logic [3:0] REG_RXEOB  = 4'hE;
    localparam logic [3:0] REG_RXDERR = 4'hF;

    // banked windows: addr[8:5] picks the window, addr[4:0] the channel
    localparam logic [3:0] WIN_TXPTR  = 4'hD;
    localparam logic [3:0] WIN_RXPTR  = 4'hE;
    localparam logic [3:0] WIN_RXSIZE = 4'hF;

    localparam logic [DATA_W-1:0] CFG_RESET = 32'h0007_C000;
    localparam logic [DATA_W-1:0] CFG_KEEP  = 32'h00FF_C087;
    localparam int                SOFT_BIT  = 31;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/chreg_status_bank.sv
module chreg_status_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic         clr_we,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] set_bits,
    output logic [W-1:0] q
);

    logic [W-1:0] clr_mask;

    always_comb begin
        clr_mask = clr_we ? clr_bits : '0;
    end

    // soft reset beats engine sets; engine sets beat software clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (soft_clr) begin
            q <= '0;
        end else begin
            q <= (q & ~clr_mask) | set_bits;
        end
    end

endmodule

// File: rtl/chreg_window.sv
module chreg_window #(
    parameter int N      = 4,
    parameter int KEEP_W = 32,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val
);

    logic [KEEP_W-1:0] slot [N];

    // no reset: contents survive hard and soft reset
    always_ff @(posedge clk) begin
        for (int c = 0; c < N; c++) begin
            if (we && idx == IDX_W'(c)) begin
                slot[c] <= wdata[KEEP_W-1:0];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int c = 0; c < N; c++) begin
            if (idx == IDX_W'(c)) begin
                rd_val = DATA_W'(slot[c]);
            end
        end
    end

endmodule

// File: rtl/chreg_bus_fsm.sv
module chreg_bus_fsm #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    import chreg_pkg::*;

    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_en ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_en ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end

    always_comb begin
        rvalid = (state_q == BUS_RESP);
    end

endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile #(
    parameter int TX_CH = 4,
    parameter int RX_CH = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [chreg_pkg::ADDR_W-1:0] addr,
    input  logic [chreg_pkg::DATA_W-1:0] wdata,
    output logic [chreg_pkg::DATA_W-1:0] rdata,
    output logic                        rvalid,
    input  logic [chreg_pkg::DATA_W-1:0] err_set,
    input  logic [TX_CH-1:0]            tx_eob_set,
    input  logic [TX_CH-1:0]            tx_derr_set,
    input  logic [RX_CH-1:0]            rx_eob_set,
    input  logic [RX_CH-1:0]            rx_derr_set
);

    import chreg_pkg::*;

    logic [3:0]        win_sel;
    logic [3:0]        reg_sel;
    logic [IDX_W-1:0]  ch_idx;
    logic              scal_hit;
    logic              soft_rst;

    logic [DATA_W-1:0]  cfg_q;
    logic [IEN_W-1:0]   ien_q;
    logic [TXACT_W-1:0] tx_set_q, tx_rst_q;
    logic [RXACT_W-1:0] rx_set_q, rx_rst_q;
    logic [DATA_W-1:0]  err_q;
    logic [TX_CH-1:0]   tx_eob_q, tx_derr_q;
    logic [RX_CH-1:0]   rx_eob_q, rx_derr_q;
    logic [DATA_W-1:0]  txp_rd, rxp_rd, rxsz_rd, rd_val;

    assign win_sel  = addr[8:5];
    assign reg_sel  = addr[3:0];
    assign ch_idx   = addr[IDX_W-1:0];
    assign scal_hit = (addr[8:4] == 5'd0);
    assign soft_rst = wr_en && scal_hit && (reg_sel == REG_CFG) && wdata[SOFT_BIT];

    function automatic logic wr_hit(input logic [3:0] sel);
        return wr_en && scal_hit && (reg_sel == sel);
    endfunction

    // configuration word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_hit(REG_CFG)) begin
            cfg_q <= wdata & CFG_KEEP;
        end
    end

    // enable and channel-active words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q    <= '0;
            tx_set_q <= '0;
            tx_rst_q <= '0;
            rx_set_q <= '0;
            rx_rst_q <= '0;
        end else if (soft_rst) begin
            ien_q    <= '0;
            tx_set_q <= '0;
            tx_rst_q <= '0;
            rx_set_q <= '0;
            rx_rst_q <= '0;
        end else begin
            if (wr_hit(REG_IEN))   ien_q    <= wdata[IEN_W-1:0];
            if (wr_hit(REG_TXSET)) tx_set_q <= wdata[DATA_W-1 -: TXACT_W];
            if (wr_hit(REG_TXRST)) tx_rst_q <= wdata[DATA_W-1 -: TXACT_W];
            if (wr_hit(REG_RXSET)) rx_set_q <= wdata[DATA_W-1 -: RXACT_W];
            if (wr_hit(REG_RXRST)) rx_rst_q <= wdata[DATA_W-1 -: RXACT_W];
        end
    end

    // write-one-to-clear status words
    chreg_status_bank #(.W(DATA_W)) u_err (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
        .clr_we(wr_hit(REG_ERR)), .clr_bits(wdata),
        .set_bits(err_set), .q(err_q));

    chreg_status_bank #(.W(TX_CH)) u_tx_eob (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
        .clr_we(wr_hit(REG_TXEOB)), .clr_bits(wdata[TX_CH-1:0]),
        .set_bits(tx_eob_set), .q(tx_eob_q));

    chreg_status_bank #(.W(TX_CH)) u_tx_derr (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
        .clr_we(wr_hit(REG_TXDERR)), .clr_bits(wdata[TX_CH-1:0]),
        .set_bits(tx_derr_set), .q(tx_derr_q));

    chreg_status_bank #(.W(RX_CH)) u_rx_eob (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
        .clr_we(wr_hit(REG_RXEOB)), .clr_bits(wdata[RX_CH-1:0]),
        .set_bits(rx_eob_set), .q(rx_eob_q));

    chreg_status_bank #(.W(RX_CH)) u_rx_derr (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
        .clr_we(wr_hit(REG_RXDERR)), .clr_bits(wdata[RX_CH-1:0]),
        .set_bits(rx_derr_set), .q(rx_derr_q));

    // per-channel windows
    chreg_window #(.N(TX_CH), .KEEP_W(DATA_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_txptr (
        .clk(clk), .we(wr_en && win_sel == WIN_TXPTR), .idx(ch_idx),
        .wdata(wdata), .rd_val(txp_rd));

    chreg_window #(.N(RX_CH), .KEEP_W(DATA_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rxptr (
        .clk(clk), .we(wr_en && win_sel == WIN_RXPTR), .idx(ch_idx),
        .wdata(wdata), .rd_val(rxp_rd));

    chreg_window #(.N(RX_CH), .KEEP_W(RXSZ_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rxsize (
        .clk(clk), .we(wr_en && win_sel == WIN_RXSIZE), .idx(ch_idx),
        .wdata(wdata), .rd_val(rxsz_rd));

    // read selection
    always_comb begin
        rd_val = '0;
        if (win_sel == WIN_TXPTR) begin
            rd_val = txp_rd;
        end else if (win_sel == WIN_RXPTR) begin
            rd_val = rxp_rd;
        end else if (win_sel == WIN_RXSIZE) begin
            rd_val = rxsz_rd;
        end else if (scal_hit) begin
            case (reg_sel)
                REG_CFG:    rd_val = cfg_q;
                REG_IEN:    rd_val = DATA_W'(ien_q);
                REG_ERR:    rd_val = err_q;
                REG_TXSET:  rd_val = {tx_set_q, {(DATA_W-TXACT_W){1'b0}}};
                REG_TXRST:  rd_val = {tx_rst_q, {(DATA_W-TXACT_W){1'b0}}};
                REG_TXEOB:  rd_val = DATA_W'(tx_eob_q);
                REG_TXDERR: rd_val = DATA_W'(tx_derr_q);
                REG_RXSET:  rd_val = {rx_set_q, {(DATA_W-RXACT_W){1'b0}}};
                REG_RXRST:  rd_val = {rx_rst_q, {(DATA_W-RXACT_W){1'b0}}};
                REG_RXEOB:  rd_val = DATA_W'(rx_eob_q);
                REG_RXDERR: rd_val = DATA_W'(rx_derr_q);
                default:    rd_val = '0;
            endcase
        end
    end

    chreg_bus_fsm #(.DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_val(rd_val),
        .rdata(rdata), .rvalid(rvalid));

endmodule

// File: rtl/dma_chan_regfile_chk.sv
module dma_chan_regfile_chk #(
    parameter int TX_CH = 4,
    parameter int RX_CH = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic                         rd_en,
    input logic [chreg_pkg::ADDR_W-1:0] addr,
    input logic [chreg_pkg::DATA_W-1:0] wdata,
    input logic [chreg_pkg::DATA_W-1:0] err_set,
    input logic [TX_CH-1:0]             tx_eob_set,
    input logic                         rvalid,
    input logic                         soft_rst,
    input logic [chreg_pkg::IEN_W-1:0]  ien_q,
    input logic [chreg_pkg::DATA_W-1:0] err_q,
    input logic [TX_CH-1:0]             tx_eob_q,
    input logic [RX_CH-1:0]             rx_derr_q
);

    import chreg_pkg::*;

    // R11
    rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    // R11
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

    // R4
    ien_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == {5'd0, REG_IEN}) |=> (ien_q == $past(wdata[IEN_W-1:0])));

    // R3
    err_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == {5'd0, REG_ERR}) |=> ((err_q & $past(wdata) & ~$past(err_set)) == '0));

    // R7
    tx_eob_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_eob_set && !soft_rst) |=> ((tx_eob_q & $past(tx_eob_set)) == $past(tx_eob_set)));

    // R2
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ien_q == '0 && err_q == '0 && tx_eob_q == '0 && rx_derr_q == '0));

endmodule

bind dma_chan_regfile dma_chan_regfile_chk #(.TX_CH(TX_CH), .RX_CH(RX_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .err_set(err_set), .tx_eob_set(tx_eob_set), .rvalid(rvalid),
    .soft_rst(soft_rst), .ien_q(ien_q), .err_q(err_q), .tx_eob_q(tx_eob_q),
    .rx_derr_q(rx_derr_q));

// File: tb/dma_chan_regfile_test.sv
`timescale 1ns/1ps
module dma_chan_regfile_test;

    localparam int TXN = 4;
    localparam int RXN = 2;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0, err_set = '0;
    logic [TXN-1:0] tx_eob_set = '0, tx_derr_set = '0;
    logic [RXN-1:0] rx_eob_set = '0, rx_derr_set = '0;
    logic [31:0] rdata;
    logic        rvalid;

    always #2 clk = ~clk;  // 250 MHz

    dma_chan_regfile #(.TX_CH(TXN), .RX_CH(RXN)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err_set(err_set),
        .tx_eob_set(tx_eob_set), .tx_derr_set(tx_derr_set),
        .rx_eob_set(rx_eob_set), .rx_derr_set(rx_derr_set));

    // behavioural reference state
    int unsigned m_cfg, m_ien, m_err, m_txs, m_txr, m_rxs, m_rxr;
    int unsigned m_teob, m_tderr, m_reob, m_rderr;
    int unsigned m_txp [32];
    int unsigned m_rxp [32];
    int unsigned m_rsz [32];
    bit          exp_rv;
    int unsigned exp_rd;
    int compared = 0, mismatched = 0;
    string cur_req = "R1";
    bit done = 0;

    localparam int unsigned TXM = (1 << TXN) - 1;
    localparam int unsigned RXM = (1 << RXN) - 1;

    function automatic int unsigned m_read(int unsigned a);
        if (a >= 32'h1A0 && a < 32'h1A0 + TXN) return m_txp[a - 32'h1A0];
        if (a >= 32'h1C0 && a < 32'h1C0 + RXN) return m_rxp[a - 32'h1C0];
        if (a >= 32'h1E0 && a < 32'h1E0 + RXN) return m_rsz[a - 32'h1E0];
        case (a)
            32'h000: return m_cfg;
            32'h001: return m_ien;
            32'h002: return m_err;
            32'h008: return m_txs;
            32'h009: return m_txr;
            32'h00A: return m_teob;
            32'h00B: return m_tderr;
            32'h00C: return m_rxs;
            32'h00D: return m_rxr;
            32'h00E: return m_reob;
            32'h00F: return m_rderr;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned w1c(int unsigned q, bit hit, int unsigned d, int unsigned s);
        return (q & ~(hit ? d : 0)) | s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 32'h0007C000; m_ien = 0; m_err = 0;
            m_txs = 0; m_txr = 0; m_rxs = 0; m_rxr = 0;
            m_teob = 0; m_tderr = 0; m_reob = 0; m_rderr = 0;
            exp_rv = 0;
        end else begin
            int unsigned a;
            a = addr;
            exp_rv = rd_en;
            if (rd_en) exp_rd = m_read(a);
            if (wr_en && a == 0 && wdata[31]) begin
                m_ien = 0; m_err = 0; m_txs = 0; m_txr = 0; m_rxs = 0; m_rxr = 0;
                m_teob = 0; m_tderr = 0; m_reob = 0; m_rderr = 0;
                m_cfg = wdata & 32'h00FFC087;
            end else begin
                m_err   = w1c(m_err,   wr_en && a == 2,    wdata, err_set);
                m_teob  = w1c(m_teob,  wr_en && a == 32'hA, wdata & TXM, tx_eob_set);
                m_tderr = w1c(m_tderr, wr_en && a == 32'hB, wdata & TXM, tx_derr_set);
                m_reob  = w1c(m_reob,  wr_en && a == 32'hE, wdata & RXM, rx_eob_set);
                m_rderr = w1c(m_rderr, wr_en && a == 32'hF, wdata & RXM, rx_derr_set);
                if (wr_en) begin
                    case (a)
                        32'h000: m_cfg = wdata & 32'h00FFC087;
                        32'h001: m_ien = wdata & 32'h1F;
                        32'h008: m_txs = wdata & 32'hF0000000;
                        32'h009: m_txr = wdata & 32'hF0000000;
                        32'h00C: m_rxs = wdata & 32'hC0000000;
                        32'h00D: m_rxr = wdata & 32'hC0000000;
                        default: ;
                    endcase
                    if (a >= 32'h1A0 && a < 32'h1A0 + TXN) m_txp[a - 32'h1A0] = wdata;
                    if (a >= 32'h1C0 && a < 32'h1C0 + RXN) m_rxp[a - 32'h1C0] = wdata;
                    if (a >= 32'h1E0 && a < 32'h1E0 + RXN) m_rsz[a - 32'h1E0] = wdata & 32'hFF;
                end
            end
        end
    end

    // compare on every clock, mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if (rvalid !== exp_rv || (exp_rv && rdata !== exp_rd)) begin
                mismatched++;
                $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                         cur_req, rvalid, rdata, exp_rv, exp_rd);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a);
        rd_en = 1'b1; addr = a;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic rd_scalars();
        for (int i = 0; i < 16; i++) rd(9'(i));
    endtask

    task automatic rd_windows();
        for (int i = 0; i < 6; i++) begin
            rd(9'h1A0 + 9'(i)); rd(9'h1C0 + 9'(i)); rd(9'h1E0 + 9'(i));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        cur_req = "R1";  // reset values
        rd_scalars();

        cur_req = "R4";
        wr(9'h001, 32'hFFFF_FFFF); rd(9'h001);
        wr(9'h001, 32'h0000_0035); rd(9'h001);

        cur_req = "R5";
        wr(9'h008, 32'hFFFF_FFFF); wr(9'h009, 32'hA5A5_A5A5);
        wr(9'h00C, 32'hFFFF_FFFF); wr(9'h00D, 32'h7FFF_FFFF);
        rd(9'h008); rd(9'h009); rd(9'h00C); rd(9'h00D);

        cur_req = "R6";
        tx_eob_set = 4'b1010; tx_derr_set = 4'b0101; rx_eob_set = 2'b10;
        rx_derr_set = 2'b11; err_set = 32'h8000_0011;
        tick();
        tx_eob_set = '0; tx_derr_set = '0; rx_eob_set = '0; rx_derr_set = '0; err_set = '0;
        rd_scalars();

        cur_req = "R3";
        wr(9'h00A, 32'h0000_0002); wr(9'h00B, 32'hFFFF_FFF4);
        wr(9'h002, 32'h0000_0010); wr(9'h00F, 32'h0000_0001);
        rd_scalars();

        cur_req = "R7";  // clear and set on the same bit, same cycle
        wr_en = 1'b1; addr = 9'h00A; wdata = 32'h0000_0008; tx_eob_set = 4'b1001;
        tick();
        wr_en = 1'b0; tx_eob_set = '0;
        rd(9'h00A);
        wr_en = 1'b1; addr = 9'h002; wdata = 32'hFFFF_FFFF; err_set = 32'h0000_0100;
        tick();
        wr_en = 1'b0; err_set = '0;
        rd(9'h002);

        cur_req = "R8";
        for (int i = 0; i < TXN; i++) wr(9'h1A0 + 9'(i), 32'h1000_0000 + 32'(i * 32'h111));
        for (int i = 0; i < RXN; i++) wr(9'h1C0 + 9'(i), 32'hC000_0F00 + 32'(i));
        for (int i = 0; i < RXN; i++) wr(9'h1E0 + 9'(i), 32'h0000_12A0 + 32'(i * 7));
        rd_windows();

        cur_req = "R9";
        wr(9'h1A0 + 9'(TXN), 32'hDEAD_BEEF); wr(9'h1BF, 32'hDEAD_BEEF);
        wr(9'h1C0 + 9'(RXN), 32'hDEAD_BEEF); wr(9'h1E0 + 9'(RXN), 32'hDEAD_BEEF);
        wr(9'h003, 32'hFFFF_FFFF); wr(9'h010, 32'hFFFF_FFFF); wr(9'h100, 32'hFFFF_FFFF);
        rd(9'h1BF); rd(9'h003); rd(9'h010); rd(9'h100);
        rd_windows();
        rd_scalars();

        cur_req = "R2";  // soft reset with a coinciding engine set (R7)
        tx_derr_set = 4'b1111; rx_eob_set = 2'b01;
        wr(9'h000, 32'hFFFF_FFFF);
        tx_derr_set = '0; rx_eob_set = '0;
        rd_scalars();
        wr(9'h000, 32'h1234_5678); rd(9'h000);

        cur_req = "R10";
        rd_windows();
        #1 rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        rd_scalars();
        rd_windows();

        cur_req = "R11";  // back-to-back and spaced reads
        rd(9'h1A1); rd(9'h1C1); rd(9'h000);
        tick();
        rd(9'h1E1);
        tick(); tick();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule